// File: doc/BRIEF.md
# Serial Port with Break Control

This block is an eight-bit serial port with a transmitter, a receiver, an error and status register, and a small register bus. It runs either in asynchronous mode, with start, data, optional even-parity and stop bits, or in clocked synchronous mode, where it shifts eight bits with no framing and drives a serial clock. Both modes share the shift datapath and one baud divider. The divider produces a tick every `BAUD+1` clocks, and each bit lasts `OS` ticks.

Software owns the transmit pin whenever the transmitter is disabled. In that state a pin-direction bit and a pin-data bit drive it, so the line can be held at mark or pulled low as a break. Disabling the transmitter drops any frame in flight at once. A halt bit, set by reset, freezes the whole port until software clears it. The receiver keeps sampling through a line break, so the framing flag comes back after it is cleared. In synchronous mode, pending receive errors hold off any new transmission.

The register bus has no back-pressure. A write is taken in the cycle `reg_wr` is high, and reads are combinational. Register addresses are: 0 halt, 1 control, 2 transmit data (write), 3 receive data, 4 status, 5 baud divisor.

Top module: `sio_break_port`

## Requirements
- R1: After reset the halt bit (address 0, bit 0) is 1. While halted, writes to any other address are ignored and reads of any other address return 0. Writing 0 to address 0 releases the port.
- R2: With transmitter enable (control bit 0) at 0, `txd_oe` equals pin-direction (control bit 4). `txd_o` equals pin-data (control bit 5). Direction 1 with data 1 holds the line at mark.
- R3: Clearing transmitter enable aborts a frame in progress in the same cycle: the busy flag (status bit 6) drops. With direction 1 and data 0 the line stays low (break). Re-enabling does not resend the dropped byte.
- R4: An asynchronous frame is, in order: one low start bit, eight data bits with the least significant first, an even-parity bit when parity enable (control bit 2) is 1, and one high stop bit. With divisor 0, each bit lasts 16 clocks.
- R5: A received frame with correct parity and stop bit loads the receive data register (address 3) and sets receive-full (status bit 1), with no error flags set. Writing 1 to any of status bits 1 to 4 clears that flag.
- R6: An all-low line gives a frame whose stop bit is 0, which sets the framing flag (status bit 3). The receiver keeps running, so the flag is set again one frame after software clears it while the line stays low.
- R7: Clearing receiver enable (control bit 1) does not clear the overrun, framing or parity flags.
- R8: A frame that completes while receive-full is 1 sets overrun (status bit 2) and leaves the receive data register unchanged.
- R9: A write to transmit data is always accepted. If the earlier byte has not yet been loaded into the shifter, the new byte replaces it and the earlier byte is never sent.
- R10: Transmit-empty (status bit 0) is 1 after reset. It goes to 0 on a transmit data write and back to 1 when the shifter loads that byte at frame start.
- R11: With sync mode (control bit 3) set, no transmission starts while overrun, framing or parity is 1. Once the flags are clear, eight bits are shifted out LSB first, each valid at the rising edge of `sclk_o`. The receiver captures `rxd_i` on the same edges.
- R12: Status bit 5 shows the synchronized level of `rxd_i` at any time.
- R13: The baud divisor (address 5) stretches each bit to 16 x (divisor + 1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit level |
| txd_oe | output | 1 | Transmit pin drive enable (0 = high impedance) |
| sclk_o | output | 1 | Serial clock in sync mode, idles high |

## Verification
The bench builds the port with its defaults: OS = 16 and an 8-bit divisor. It keeps the divisor at 0 for most of the run, so a bit lasts 16 clocks. That makes it cheap to loop the transmit line back to the receiver and sweep all 256 byte values with parity, checking both the sampled frame and the received byte. A shorter sweep runs without parity. A single frame at divisor 2 confirms that bit length scales with the divisor. Break, abort, overwrite, overrun and the sync interlock are each driven as directed sequences, and their expected values are worked out from the frame arithmetic.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [2:0] A_STOP = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_BAUD = 3'd5;

  // status bit positions
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_OVR  = 2;
  localparam int S_FER  = 3;
  localparam int S_PER  = 4;

  typedef struct packed {
    logic pin_dat;
    logic pin_dir;
    logic sync;
    logic par_en;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R13
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div != '0 |=> !tick || div == '0);
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       sync,
  input  logic       par_en,
  input  logic       have_data,
  input  logic       block,
  input  logic [7:0] data,
  output logic       line,
  output logic       sclk,
  output logic       load,
  output logic       samp,
  output logic       busy
);
  localparam int PH_W = $clog2(OS);
  localparam logic [PH_W-1:0] PH_MID = PH_W'(OS/2 - 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OS - 1);

  logic            busy_q;
  logic [10:0]     sh;
  logic [3:0]      left;
  logic [PH_W-1:0] ph;

  assign load = en && tick && !busy_q && have_data && !block;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy_q <= 1'b0;
      sh     <= '1;
      left   <= '0;
      ph     <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      ph     <= '0;
      if (sync) begin
        sh   <= {3'b111, data};
        left <= 4'd8;
      end else begin
        sh   <= {1'b1, (par_en ? ^data : 1'b1), data, 1'b0};
        left <= par_en ? 4'd11 : 4'd10;
      end
    end else if (busy_q && tick) begin
      if (ph == PH_END) begin
        ph   <= '0;
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy_q <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign line = busy_q ? sh[0] : 1'b1;
  assign sclk = (busy_q && sync) ? (ph > PH_MID) : 1'b1;
  assign samp = busy_q && sync && tick && (ph == PH_MID);
  assign busy = busy_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       sync,
  input  logic       par_en,
  input  logic       rxd,
  input  logic       samp,
  output logic       done,
  output logic [7:0] data,
  output logic       fer,
  output logic       per
);
  localparam int PH_W = $clog2(OS);
  localparam logic [PH_W-1:0] PH_MID = PH_W'(OS/2 - 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(OS - 1);

  rx_st_t          st;
  logic [PH_W-1:0] ph;
  logic [3:0]      idx;
  logic [8:0]      acc;
  logic [3:0]      stop_idx;

  assign stop_idx = par_en ? 4'd9 : 4'd8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; ph <= '0; idx <= '0; acc <= '0;
      done <= 1'b0; fer <= 1'b0; per <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= RX_IDLE; ph <= '0; idx <= '0;
      end else if (sync) begin
        st <= RX_IDLE;
        ph <= '0;
        if (samp) begin
          acc <= {rxd, acc[8:1]};
          if (idx == 4'd7) begin
            idx <= '0; done <= 1'b1; fer <= 1'b0; per <= 1'b0;
          end else begin
            idx <= idx + 4'd1;
          end
        end
      end else if (tick) begin
        case (st)
          RX_IDLE:
            if (!rxd) begin st <= RX_START; ph <= '0; end
          RX_START:
            if (ph == PH_MID) begin
              ph  <= '0;
              idx <= '0;
              st  <= rxd ? RX_IDLE : RX_BITS;
            end else begin
              ph <= ph + 1'b1;
            end
          RX_BITS:
            if (ph == PH_END) begin
              ph <= '0;
              if (idx == stop_idx) begin
                st   <= RX_IDLE;
                idx  <= '0;
                done <= 1'b1;
                fer  <= !rxd;
                per  <= par_en && (^acc);
              end else begin
                acc <= {rxd, acc[8:1]};
                idx <= idx + 4'd1;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign data = (par_en && !sync) ? acc[7:0] : acc[8:1];
endmodule

// File: rtl/sio_break_port.sv
module sio_break_port
  import sio_pkg::*;
#(
  parameter int OS    = 16,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       txd_oe,
  output logic       sclk_o
);
  logic             halt_q;
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] baud_q;
  logic [7:0]       tx_buf_q, rx_buf_q;
  logic             tx_empty_q, rx_full_q, ovr_q, fer_q, per_q;
  logic             rxd_m, rxd_s;

  logic       run, tick, tx_load, tx_samp, tx_busy, tx_line, tx_block;
  logic       rx_done, rx_fer, rx_per;
  logic [7:0] rx_data;
  logic       wr_ok, wr_tx, wr_st;

  assign run      = !halt_q;
  assign wr_ok    = reg_wr && (run || reg_addr == A_STOP);
  assign wr_tx    = wr_ok && reg_addr == A_TXD;
  assign wr_st    = wr_ok && reg_addr == A_STAT;
  assign tx_block = ctrl_q.sync && (ovr_q || fer_q || per_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (wr_ok) begin
      if (reg_addr == A_STOP) halt_q <= reg_wdata[0];
      if (reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[5:0]);
      if (reg_addr == A_BAUD) baud_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf_q <= '0; tx_empty_q <= 1'b1;
      rx_buf_q <= '0; rx_full_q <= 1'b0;
      ovr_q <= 1'b0; fer_q <= 1'b0; per_q <= 1'b0;
    end else begin
      if (tx_load) tx_empty_q <= 1'b1;
      if (wr_tx) begin
        tx_buf_q   <= reg_wdata;
        tx_empty_q <= 1'b0;
      end
      if (wr_st && reg_wdata[S_RXF]) rx_full_q <= 1'b0;
      if (wr_st && reg_wdata[S_OVR]) ovr_q     <= 1'b0;
      if (wr_st && reg_wdata[S_FER]) fer_q     <= 1'b0;
      if (wr_st && reg_wdata[S_PER]) per_q     <= 1'b0;
      if (rx_done) begin
        if (rx_full_q) ovr_q <= 1'b1;
        else begin
          rx_buf_q  <= rx_data;
          rx_full_q <= 1'b1;
        end
        if (rx_fer) fer_q <= 1'b1;
        if (rx_per) per_q <= 1'b1;
      end
    end
  end

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_q), .tick(tick)
  );

  sio_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.tx_en && run), .tick(tick),
    .sync(ctrl_q.sync), .par_en(ctrl_q.par_en), .have_data(!tx_empty_q),
    .block(tx_block), .data(tx_buf_q), .line(tx_line), .sclk(sclk_o),
    .load(tx_load), .samp(tx_samp), .busy(tx_busy)
  );

  sio_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.rx_en && run), .tick(tick),
    .sync(ctrl_q.sync), .par_en(ctrl_q.par_en), .rxd(rxd_s), .samp(tx_samp),
    .done(rx_done), .data(rx_data), .fer(rx_fer), .per(rx_per)
  );

  assign txd_o  = ctrl_q.tx_en ? tx_line : ctrl_q.pin_dat;
  assign txd_oe = ctrl_q.tx_en ? 1'b1    : ctrl_q.pin_dir;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STOP: reg_rdata = {7'd0, halt_q};
      A_CTRL: reg_rdata = {2'd0, ctrl_q};
      A_RXD:  reg_rdata = rx_buf_q;
      A_STAT: reg_rdata = {1'b0, tx_busy, rxd_s, per_q, fer_q, ovr_q, rx_full_q, tx_empty_q};
      A_BAUD: reg_rdata = 8'(baud_q);
      default: reg_rdata = '0;
    endcase
    if (halt_q && reg_addr != A_STOP) reg_rdata = '0;
  end

  // R1
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(ctrl_q));
  // R9
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tx_empty_q && tx_buf_q == $past(reg_wdata));
  // R10
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !wr_tx |=> tx_empty_q);
  // R11
  sync_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.sync && (ovr_q || fer_q || per_q) && !tx_busy |=> !tx_busy);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fer_q && !(wr_st && reg_wdata[S_FER]) |=> fer_q);
  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full_q |=> ovr_q && $stable(rx_buf_q));
endmodule

// File: tb/sio_break_port_test.sv
module sio_break_port_test;
  import sio_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       drv_rxd = 1'b1;
  logic       loop_en = 1'b0;
  logic       txd_o, txd_oe, sclk_o, line, rxd_i;

  assign line  = txd_oe ? txd_o : 1'b1;
  assign rxd_i = loop_en ? line : drv_rxd;

  sio_break_port #(.OS(16), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd_i(rxd_i),
    .txd_o(txd_o), .txd_oe(txd_oe), .sclk_o(sclk_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic grab_async(input int per, input int nb, output logic [10:0] bits);
    bits = '1;
    @(negedge clk);
    while (line) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      bits[i] = line;
      if (i < nb - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic grab_sync(output logic [7:0] b);
    int n;
    logic p;
    n = 0; p = sclk_o; b = '0;
    while (n < 8) begin
      @(negedge clk);
      if (!p && sclk_o) begin
        b[n] = txd_o;
        n++;
      end
      p = sclk_o;
    end
  endtask

  task automatic count_low(input int cyc, input bit use_sclk, output int lows);
    lows = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (use_sclk ? !sclk_o : !line) lows++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, v8, sb;
    logic [10:0] fb, f1, f2, ex;
    int          n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and halt
    rd(A_STOP, d);  chk(d == 8'd1, "R1 halt after reset", d, 1);
    rd(A_STAT, d);  chk(d == 8'd0, "R1 halted read", d, 0);
    chk(txd_oe == 1'b0, "R1 pin undriven", txd_oe, 0);
    wr(A_CTRL, 8'h3F);
    wr(A_TXD, 8'h99);
    chk(txd_oe == 1'b0, "R1 ctrl write ignored", txd_oe, 0);
    wr(A_STOP, 8'h00);
    rd(A_CTRL, d);  chk(d == 8'd0, "R1 ctrl unchanged", d, 0);
    rd(A_STAT, d);  chk(d[S_TXE] == 1'b1, "R1 R10 tx empty", d[S_TXE], 1);

    // R12 raw line level
    drv_rxd = 1'b1; repeat (4) @(negedge clk);
    rd(A_STAT, d);  chk(d[5] == 1'b1, "R12 level high", d[5], 1);
    drv_rxd = 1'b0; repeat (4) @(negedge clk);
    rd(A_STAT, d);  chk(d[5] == 1'b0, "R12 level low", d[5], 0);
    drv_rxd = 1'b1; repeat (4) @(negedge clk);

    // R2 port control of the pin
    wr(A_CTRL, 8'h30); chk(txd_oe && txd_o, "R2 mark", {txd_oe, txd_o}, 3);
    wr(A_CTRL, 8'h20); chk(!txd_oe, "R2 undriven", txd_oe, 0);
    wr(A_CTRL, 8'h10); chk(txd_oe && !txd_o, "R2 low", {txd_oe, txd_o}, 2);

    // R4 R5 full sweep with parity, loopback
    wr(A_CTRL, 8'h07);
    loop_en = 1'b1;
    wr(A_STAT, 8'h1E);
    for (int v = 0; v < 256; v++) begin
      v8 = 8'(v);
      fork
        grab_async(16, 11, fb);
        wr(A_TXD, v8);
      join
      ex = {1'b1, ^v8, v8, 1'b0};
      chk(fb == ex, "R4 parity frame", fb, ex);
      repeat (20) @(negedge clk);
      rd(A_STAT, d); chk(d[4:1] == 4'b0001, "R5 flags", d[4:1], 1);
      rd(A_RXD, d);  chk(d == v8, "R5 data", d, v8);
      wr(A_STAT, 8'h02);
    end

    // R4 R5 no-parity sweep
    wr(A_CTRL, 8'h03);
    for (int v = 0; v < 16; v++) begin
      v8 = 8'(v * 17 + 3);
      fork
        grab_async(16, 10, fb);
        wr(A_TXD, v8);
      join
      ex = {1'b0, 1'b1, v8, 1'b0};
      chk(fb[9:0] == ex[9:0], "R4 plain frame", fb[9:0], ex[9:0]);
      repeat (20) @(negedge clk);
      rd(A_RXD, d);  chk(d == v8, "R5 plain data", d, v8);
      wr(A_STAT, 8'h02);
    end

    // R13 divisor 2 -> 48 clocks per bit
    wr(A_BAUD, 8'd2);
    fork
      grab_async(48, 10, fb);
      wr(A_TXD, 8'h5A);
    join
    chk(fb[9:0] == {1'b1, 8'h5A, 1'b0}, "R13 slow frame", fb[9:0], {1'b1, 8'h5A, 1'b0});
    repeat (60) @(negedge clk);
    rd(A_RXD, d); chk(d == 8'h5A, "R13 slow rx", d, 8'h5A);
    wr(A_STAT, 8'h1E);
    wr(A_BAUD, 8'd0);

    // R9 R10 overwrite of unloaded byte
    fork
      begin
        grab_async(16, 10, f1);
        grab_async(16, 10, f2);
      end
      begin
        wr(A_TXD, 8'hA1);
        wr(A_TXD, 8'hB2);
        rd(A_STAT, d); chk(d[S_TXE] == 1'b0, "R10 empty low after write", d[S_TXE], 0);
        wr(A_TXD, 8'hC3);
      end
    join
    chk(f1[9:0] == {1'b1, 8'hA1, 1'b0}, "R9 first byte", f1[9:0], {1'b1, 8'hA1, 1'b0});
    chk(f2[9:0] == {1'b1, 8'hC3, 1'b0}, "R9 last write wins", f2[9:0], {1'b1, 8'hC3, 1'b0});
    rd(A_STAT, d); chk(d[S_TXE] == 1'b1, "R10 empty after load", d[S_TXE], 1);
    count_low(300, 1'b0, n); chk(n == 0, "R9 no third frame", n, 0);
    wr(A_STAT, 8'h1E);

    // R8 overrun
    fork grab_async(16, 10, fb); wr(A_TXD, 8'h11); join
    repeat (20) @(negedge clk);
    fork grab_async(16, 10, fb); wr(A_TXD, 8'h22); join
    repeat (20) @(negedge clk);
    rd(A_STAT, d); chk(d[2:1] == 2'b11, "R8 overrun flag", d[2:1], 3);
    rd(A_RXD, d);  chk(d == 8'h11, "R8 data kept", d, 8'h11);
    wr(A_STAT, 8'h1E);
    rd(A_STAT, d); chk(d[4:1] == 4'd0, "R5 clear flags", d[4:1], 0);

    // R3 abort into break
    loop_en = 1'b0;
    wr(A_CTRL, 8'h13);
    wr(A_TXD, 8'h55);
    repeat (60) @(negedge clk);
    rd(A_STAT, d); chk(d[6] == 1'b1, "R3 busy mid frame", d[6], 1);
    wr(A_CTRL, 8'h12);
    chk(txd_oe && !txd_o, "R3 break at once", {txd_oe, txd_o}, 2);
    rd(A_STAT, d); chk(d[6] == 1'b0, "R3 aborted", d[6], 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (line) n++; end
    chk(n == 0, "R3 break held", n, 0);
    wr(A_CTRL, 8'h13);
    count_low(300, 1'b0, n); chk(n == 0, "R3 no resend", n, 0);

    // R6 break on receive
    wr(A_CTRL, 8'h06);
    wr(A_STAT, 8'h1E);
    drv_rxd = 1'b0;
    repeat (400) @(negedge clk);
    rd(A_STAT, d); chk(d[S_FER] == 1'b1, "R6 framing on break", d[S_FER], 1);
    chk(d[5] == 1'b0, "R12 low in break", d[5], 0);
    wr(A_STAT, 8'h1E);
    repeat (250) @(negedge clk);
    rd(A_STAT, d); chk(d[S_FER] == 1'b1, "R6 framing again", d[S_FER], 1);

    // R7 flags survive receiver disable
    wr(A_CTRL, 8'h04);
    drv_rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(A_STAT, d); chk(d[S_FER] == 1'b1, "R7 flag kept", d[S_FER], 1);

    // R11 sync interlock
    wr(A_CTRL, 8'h09);
    wr(A_TXD, 8'h3C);
    count_low(300, 1'b1, n); chk(n == 0, "R11 blocked no clock", n, 0);
    rd(A_STAT, d); chk(d[S_TXE] == 1'b0, "R11 byte waits", d[S_TXE], 0);
    fork
      grab_sync(sb);
      wr(A_STAT, 8'h1E);
    join
    chk(sb == 8'h3C, "R11 sync bits", sb, 8'h3C);
    rd(A_STAT, d); chk(d[S_TXE] == 1'b1, "R11 loaded", d[S_TXE], 1);
    repeat (20) @(negedge clk);

    // R11 sync receive in loopback
    wr(A_CTRL, 8'h0B);
    loop_en = 1'b1;
    fork
      grab_sync(sb);
      wr(A_TXD, 8'hC5);
    join
    chk(sb == 8'hC5, "R11 sync bits 2", sb, 8'hC5);
    repeat (20) @(negedge clk);
    rd(A_RXD, d);  chk(d == 8'hC5, "R11 sync receive", d, 8'hC5);
    rd(A_STAT, d); chk(d[4:1] == 4'b0001, "R11 sync flags", d[4:1], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule